// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is one bank of general-purpose I/O lines. Software reaches it through a small register window. Each access is a single cycle and uses an address, a write strobe, write data and combinational read data. Each line has four control bits: a drive value, a direction, a blink enable and an input-inversion bit. The pads are modelled as three vectors: a driven value, a drive enable and a sampled input.

A line whose direction bit is cleared drives the pad with its stored value. If that line's blink bit is also set, the driven value is flipped by a shared square wave. The wave changes phase every `BLINK_HALF` clock cycles. A line whose direction bit is set is an input. Its pad level passes through a two-stage synchronizer and is then XORed with the line's inversion bit. The result can be read at a dedicated read-only offset.

The direction, drive value, blink enable and inversion bits are stored separately. Software can therefore set a line's output level and blink mode while the line is still an input, and the line drives those settings from the cycle in which it becomes an output.

Top module: `gpio_bank`

## Requirements
- R1: After reset every line is an input: the direction register reads all ones, `pad_oe` is all zeros, and the drive-value, blink-enable and inversion registers read zero.
- R2: The registers are word-aligned. The drive value is at 0x00, direction at 0x04, blink enable at 0x08, inversion at 0x0C and synchronized input at 0x10. A write to 0x00, 0x04, 0x08 or 0x0C takes effect at the clock edge on which `reg_we` is sampled high, and the written value reads back unchanged.
- R3: In the direction register, bit i = 1 makes line i an input (`pad_oe[i]` = 0) and bit i = 0 makes it an output (`pad_oe[i]` = 1). `pad_oe` follows a direction write from the next cycle. An output line with blink disabled drives its drive-value bit.
- R4: A read at 0x10 returns the pad inputs, delayed by exactly two clock edges, XORed bit by bit with the inversion register. An inversion bit of 1 reports the opposite of the pad level.
- R5: Offset 0x10 is read-only. A write there changes no register and no pad output.
- R6: The blink phase is 0 at reset and flips every `BLINK_HALF` clock edges. Its value is floor(n / `BLINK_HALF`) mod 2, where n is the number of edges since reset was released. An output line with its blink bit set drives its drive-value bit XOR the phase.
- R7: An input line drives `pad_out[i]` = 0, whatever its drive-value and blink bits hold.
- R8: A read at any unmapped offset returns zero. Unmapped offsets include the non-aligned ones and everything from 0x14 upward. A write to an unmapped offset changes no register.
- R9: A drive value and blink setting programmed while a line is an input appear on `pad_out` in the first cycle after the line is switched to output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_we | input | 1 | Write strobe, sampled on the clock edge |
| reg_wdata | input | LINES | Write data |
| reg_rdata | output | LINES | Combinational read data for `reg_addr` |
| pad_in | input | LINES | Asynchronous pad input levels |
| pad_out | output | LINES | Value driven to each pad |
| pad_oe | output | LINES | Per-pad drive enable |

## Verification
The bench applies several stimulus sets, each aimed at one fault:
- Alternating-bit, all-ones and walking-one words are written to every register and read back. This exposes swapped offsets and stuck or crossed bits.
- A single output line is walked across all 32 positions of the direction register. This shows that direction sets both the drive enable and the driven value for each line separately.
- A grid of pad-input patterns against inversion patterns is read, with reads taken zero, one and two edges after a pad change. This separates a wrong XOR from a wrong synchronizer depth.
- Mixed blink masks are run over several phase periods on a bank that is half inputs and half outputs. Comparing every cycle against the phase computed from the edge count catches off-by-one half-periods and leakage onto input lines.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Register window geometry
    localparam int REG_AW = 8;

    localparam logic [REG_AW-1:0] OFS_DRIVE = 8'h00;
    localparam logic [REG_AW-1:0] OFS_DIR   = 8'h04;
    localparam logic [REG_AW-1:0] OFS_BLINK = 8'h08;
    localparam logic [REG_AW-1:0] OFS_INV   = 8'h0C;
    localparam logic [REG_AW-1:0] OFS_SAMP  = 8'h10;

    typedef enum logic [2:0] {
        SEL_DRIVE,
        SEL_DIR,
        SEL_BLINK,
        SEL_INV,
        SEL_SAMP,
        SEL_NONE
    } reg_sel_e;

    // One write strobe per writable register
    typedef struct packed {
        logic drive;
        logic dir;
        logic blink;
        logic inv;
    } wr_strobe_t;

    function automatic reg_sel_e decode_offset(input logic [REG_AW-1:0] ofs);
        reg_sel_e sel;
        case (ofs)
            OFS_DRIVE: sel = SEL_DRIVE;
            OFS_DIR:   sel = SEL_DIR;
            OFS_BLINK: sel = SEL_BLINK;
            OFS_INV:   sel = SEL_INV;
            OFS_SAMP:  sel = SEL_SAMP;
            default:   sel = SEL_NONE;
        endcase
        return sel;
    endfunction

    // The sampled-input register and unmapped offsets raise no strobe
    function automatic wr_strobe_t make_strobes(input logic we, input reg_sel_e sel);
        wr_strobe_t s;
        s.drive = we && (sel == SEL_DRIVE);
        s.dir   = we && (sel == SEL_DIR);
        s.blink = we && (sel == SEL_BLINK);
        s.inv   = we && (sel == SEL_INV);
        return s;
    endfunction

    function automatic int unsigned counter_width(input int unsigned limit);
        return (limit > 1) ? $clog2(limit) : 1;
    endfunction

endpackage

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_strobe_t       stb,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] drive_q,
    output logic [LINES-1:0] dir_q,
    output logic [LINES-1:0] blink_q,
    output logic [LINES-1:0] inv_q
);

    // Direction resets to all ones: every line starts as an input
    always_ff @(posedge clk) begin
        if (rst) begin
            drive_q <= '0;
            dir_q   <= '1;
            blink_q <= '0;
            inv_q   <= '0;
        end else begin
            if (stb.drive) drive_q <= wdata;
            if (stb.dir)   dir_q   <= wdata;
            if (stb.blink) blink_q <= wdata;
            if (stb.inv)   inv_q   <= wdata;
        end
    end

endmodule

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_bank_blink.sv
module gpio_bank_blink
    import gpio_bank_pkg::*;
#(
    parameter int unsigned HALF = 12_500_000
) (
    input  logic clk,
    input  logic rst,
    output logic phase
);

    localparam int unsigned CW = counter_width(HALF);
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] tick_q;
    logic          wrap;

    assign wrap = (tick_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= '0;
            phase  <= 1'b0;
        end else if (wrap) begin
            tick_q <= '0;
            phase  <= ~phase;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int          LINES      = 32,
    parameter int unsigned BLINK_HALF = 12_500_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [LINES-1:0]  reg_wdata,
    output logic [LINES-1:0]  reg_rdata,
    input  logic [LINES-1:0]  pad_in,
    output logic [LINES-1:0]  pad_out,
    output logic [LINES-1:0]  pad_oe
);

    reg_sel_e         sel;
    wr_strobe_t       stb;
    logic [LINES-1:0] drive_q;
    logic [LINES-1:0] dir_q;
    logic [LINES-1:0] blink_q;
    logic [LINES-1:0] inv_q;
    logic [LINES-1:0] pin_sync;
    logic [LINES-1:0] sampled;
    logic             blink_phase;

    assign sel = decode_offset(reg_addr);
    assign stb = make_strobes(reg_we, sel);

    gpio_bank_regs #(.LINES(LINES)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .stb     (stb),
        .wdata   (reg_wdata),
        .drive_q (drive_q),
        .dir_q   (dir_q),
        .blink_q (blink_q),
        .inv_q   (inv_q)
    );

    gpio_bank_sync #(.WIDTH(LINES), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    gpio_bank_blink #(.HALF(BLINK_HALF)) u_blink (
        .clk   (clk),
        .rst   (rst),
        .phase (blink_phase)
    );

    assign sampled = pin_sync ^ inv_q;

    // Per-line pad driver
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign pad_oe[i]  = ~dir_q[i];
        assign pad_out[i] = ~dir_q[i] & (drive_q[i] ^ (blink_q[i] & blink_phase));
    end

    always_comb begin
        case (sel)
            SEL_DRIVE: reg_rdata = drive_q;
            SEL_DIR:   reg_rdata = dir_q;
            SEL_BLINK: reg_rdata = blink_q;
            SEL_INV:   reg_rdata = inv_q;
            SEL_SAMP:  reg_rdata = sampled;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int          LINES      = 32,
    parameter int unsigned BLINK_HALF = 12_500_000
) (
    input logic              clk,
    input logic              rst,
    input logic [REG_AW-1:0] reg_addr,
    input logic              reg_we,
    input logic [LINES-1:0]  reg_wdata,
    input logic [LINES-1:0]  reg_rdata,
    input logic [LINES-1:0]  pad_in,
    input logic [LINES-1:0]  pad_out,
    input logic [LINES-1:0]  pad_oe,
    input logic [LINES-1:0]  drive_q,
    input logic [LINES-1:0]  dir_q,
    input logic [LINES-1:0]  blink_q,
    input logic [LINES-1:0]  inv_q,
    input logic              phase
);

    logic [1:0]  settle_q;
    logic [31:0] run_q;
    logic        mapped;

    assign mapped = (reg_addr == OFS_DRIVE) || (reg_addr == OFS_DIR) ||
                    (reg_addr == OFS_BLINK) || (reg_addr == OFS_INV) ||
                    (reg_addr == OFS_SAMP);

    always_ff @(posedge clk) begin
        if (rst)                settle_q <= '0;
        else if (settle_q != 2) settle_q <= settle_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || run_q == BLINK_HALF - 1) run_q <= '0;
        else                                run_q <= run_q + 1;
    end

    // R1
    reset_inputs_chk: assert property (@(posedge clk) rst |=> (pad_oe == '0));

    // R2
    drive_write_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == OFS_DRIVE) |=> (drive_q == $past(reg_wdata)));

    // R3
    dir_to_oe_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == OFS_DIR) |=> (pad_oe == ~$past(reg_wdata)));

    // R4
    sample_path_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFS_SAMP && settle_q == 2) |-> (reg_rdata == ($past(pad_in, 2) ^ inv_q)));

    // R5
    samp_readonly_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == OFS_SAMP) |=> ($stable(drive_q) && $stable(dir_q) &&
                                              $stable(blink_q) && $stable(inv_q)));

    // R6
    blink_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q != BLINK_HALF - 1) |=> (phase == $past(phase)));

    // R6
    blink_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q == BLINK_HALF - 1) |=> (phase != $past(phase)));

    // R7
    input_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((pad_out & ~pad_oe) == '0));

    // R8
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        !mapped |-> (reg_rdata == '0));

    // R8
    unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && !mapped) |=> ($stable(drive_q) && $stable(dir_q) &&
                                 $stable(blink_q) && $stable(inv_q)));

endmodule

bind gpio_bank gpio_bank_chk #(.LINES(LINES), .BLINK_HALF(BLINK_HALF)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .drive_q   (drive_q),
    .dir_q     (dir_q),
    .blink_q   (blink_q),
    .inv_q     (inv_q),
    .phase     (blink_phase)
);

// File: tb/gpio_bank_test.sv
`timescale 1ns/1ps
module gpio_bank_test;

    localparam int          LINES = 32;
    localparam int unsigned HALF  = 5;

    localparam logic [7:0] A_DRV = 8'h00;
    localparam logic [7:0] A_DIR = 8'h04;
    localparam logic [7:0] A_BLK = 8'h08;
    localparam logic [7:0] A_INV = 8'h0C;
    localparam logic [7:0] A_SMP = 8'h10;

    logic             clk = 1'b0;
    logic             rst;
    logic [7:0]       reg_addr;
    logic             reg_we;
    logic [LINES-1:0] reg_wdata;
    logic [LINES-1:0] reg_rdata;
    logic [LINES-1:0] pad_in;
    logic [LINES-1:0] pad_out;
    logic [LINES-1:0] pad_oe;

    int  n_cmp  = 0;
    int  n_bad  = 0;
    int  edges  = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (rst) edges <= 0;
        else     edges <= edges + 1;
    end

    gpio_bank #(.LINES(LINES), .BLINK_HALF(HALF)) uut (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    function automatic logic phase_at(input int n);
        return ((n / HALF) % 2) != 0;
    endfunction

    task automatic check_regs(input string tag, input logic [31:0] e_drv, input logic [31:0] e_dir,
                              input logic [31:0] e_blk, input logic [31:0] e_inv);
        logic [31:0] v;
        rd(A_DRV, v); check({tag, " drive"}, v, e_drv);
        rd(A_DIR, v); check({tag, " dir"},   v, e_dir);
        rd(A_BLK, v); check({tag, " blink"}, v, e_blk);
        rd(A_INV, v); check({tag, " inv"},   v, e_inv);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] pats [6];
        logic [31:0] pins [4];
        logic [7:0]  bad_ofs [7];
        pats = '{32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'hFFFF_FFFF, 32'h0000_0000,
                 32'h8000_0001, 32'h1234_5678};
        pins = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hF0F0_3C3C, 32'h0F0F_C3C3};
        bad_ofs = '{8'h14, 8'h18, 8'h01, 8'h02, 8'h11, 8'h40, 8'hFC};

        rst = 1'b1; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0; pad_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check_regs("R1 reset", 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0);
        check("R1 reset pad_oe", pad_oe, 32'h0);
        check("R1 reset pad_out", pad_out, 32'h0);

        // R2 offsets and read-back
        foreach (pats[k]) begin
            wr(A_DRV, pats[k]);
            wr(A_BLK, ~pats[k]);
            wr(A_INV, {pats[k][15:0], pats[k][31:16]});
            wr(A_DIR, pats[k] ^ 32'h00FF_FF00);
            check_regs("R2 readback", pats[k], pats[k] ^ 32'h00FF_FF00, ~pats[k],
                       {pats[k][15:0], pats[k][31:16]});
        end
        for (int i = 0; i < LINES; i++) begin
            wr(A_BLK, 32'h1 << i);
            rd(A_BLK, v); check("R2 walking blink", v, 32'h1 << i);
        end
        wr(A_BLK, 32'h0);
        wr(A_INV, 32'h0);

        // R3 direction, one output line walked across the bank
        wr(A_DRV, 32'hA5C3_3C5A);
        for (int i = 0; i < LINES; i++) begin
            wr(A_DIR, ~(32'h1 << i));
            check("R3 pad_oe", pad_oe, 32'h1 << i);
            check("R3 pad_out", pad_out, 32'hA5C3_3C5A & (32'h1 << i));
        end
        wr(A_DIR, 32'hFFFF_FFFF);
        check("R3 all inputs", pad_oe, 32'h0);

        // R4 synchronizer depth
        @(negedge clk);
        pad_in = 32'hDEAD_BEEF;
        rd(A_SMP, v); check("R4 zero edges", v, 32'h0);
        @(negedge clk);
        rd(A_SMP, v); check("R4 one edge", v, 32'h0);
        @(negedge clk);
        rd(A_SMP, v); check("R4 two edges", v, 32'hDEAD_BEEF);

        // R4 polarity grid
        foreach (pins[p]) begin
            foreach (pins[q]) begin
                wr(A_INV, pins[q] ^ 32'h0000_FFFF);
                pad_in = pins[p];
                repeat (2) @(negedge clk);
                rd(A_SMP, v);
                check("R4 inversion", v, pins[p] ^ pins[q] ^ 32'h0000_FFFF);
            end
        end

        // R5 sampled register is read-only
        wr(A_DRV, 32'h1357_9BDF);
        wr(A_SMP, 32'hFFFF_FFFF);
        check_regs("R5 write to sample", 32'h1357_9BDF, 32'hFFFF_FFFF, 32'h0,
                   pins[3] ^ 32'h0000_FFFF);
        rd(A_SMP, v); check("R5 sample value", v, pins[3] ^ pins[3] ^ 32'h0000_FFFF);
        check("R5 pad_oe", pad_oe, 32'h0);

        // R6 blink on an all-output bank
        wr(A_DRV, 32'h0F0F_00FF);
        wr(A_BLK, 32'h3333_3333);
        wr(A_DIR, 32'h0);
        for (int c = 0; c < 4 * HALF + 3; c++) begin
            check("R6 blink", pad_out,
                  32'h0F0F_00FF ^ (32'h3333_3333 & {32{phase_at(edges)}}));
            @(negedge clk);
        end

        // R7 upper half inputs, all blinking
        wr(A_DRV, 32'hFFFF_FFFF);
        wr(A_BLK, 32'hFFFF_FFFF);
        wr(A_DIR, 32'hFFFF_0000);
        for (int c = 0; c < 2 * HALF + 1; c++) begin
            check("R7 pad_oe", pad_oe, 32'h0000_FFFF);
            check("R7 input lines quiet", pad_out,
                  32'h0000_FFFF & ~{32{phase_at(edges)}});
            @(negedge clk);
        end

        // R8 unmapped offsets
        wr(A_DRV, 32'h2468_ACE0);
        wr(A_BLK, 32'h0000_0F00);
        wr(A_INV, 32'h8421_8421);
        wr(A_DIR, 32'hFFFF_FFFF);
        foreach (bad_ofs[k]) begin
            wr(bad_ofs[k], 32'hFFFF_FFFF);
            wr(bad_ofs[k], 32'h0000_0000);
            rd(bad_ofs[k], v); check("R8 unmapped read", v, 32'h0);
        end
        check_regs("R8 unmapped write", 32'h2468_ACE0, 32'hFFFF_FFFF, 32'h0000_0F00, 32'h8421_8421);

        // R9 preset while input, then switch to output
        wr(A_BLK, 32'h0);
        wr(A_DRV, 32'hC0DE_F00D);
        check("R9 still input", pad_out, 32'h0);
        wr(A_DIR, 32'h0);
        check("R9 first output cycle", pad_out, 32'hC0DE_F00D);
        wr(A_DIR, 32'hFFFF_FFFF);
        wr(A_BLK, 32'hFFFF_0000);
        wr(A_DIR, 32'h0);
        check("R9 blink preset", pad_out,
              32'hC0DE_F00D ^ (32'hFFFF_0000 & {32{phase_at(edges)}}));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule